// File: doc/BRIEF.md
# Keypad Matrix Register Block

This block is the register side of an 8x8 key matrix controller. A processor reaches it over a simple 32-bit register bus with an address, a write strobe, write data, a read strobe and read data. Key events come in on a small port that has already been decoded: a valid strobe, a release flag, and a row and column index. The block does not drive or sense the matrix and does not debounce or count anything; it only keeps registers and flags, and drives one level interrupt.

A key press sets one bit in one of four scan-result registers. Each result register holds two columns: the lower column of the pair uses bits 0 to 15 and the upper column uses bits 16 to 31, indexed by row. A release wipes the whole result register of that column pair. Events count only when the matrix is enabled and one of the two scan modes is selected. The one-shot scan mode bit clears itself when an event is taken. Some status bits clear themselves when their register is read. The remaining registers (direct keys, rotary encoder, matrix key, automatic scan, debounce interval) are plain 32-bit storage that software can read and write.

Top module: `keypad_regfile`

## Requirements
- R1: After reset every register reads as zero, `irq` is low and `busRdata` is zero.
- R2: Registers sit every 8 bytes: control 0x00, direct key 0x08, rotary 0x10, matrix key 0x18, auto scan 0x20, scan results 0x28/0x30/0x38/0x40 (column pairs 0-1, 2-3, 4-5, 6-7), debounce 0x48; a write stores all 32 bits, and read data appears on `busRdata` in the cycle after `busRe`.
- R3: A key event is taken only when control bit 12 (matrix enable) is set and bit 30 (one-shot scan) or bit 29 (scan on activity) is set; otherwise no register and no interrupt changes.
- R4: A taken press sets bit (row + 16 x (column mod 2)) in the result register of pair column/2, keeping the bits already set.
- R5: A taken release clears the whole result register of its column pair to zero and leaves the other result registers unchanged.
- R6: A taken event while control bit 30 is set clears bit 30; bit 29 is not changed by events.
- R7: A taken event with control bit 11 (interrupt enable) set sets control bit 22 and drives `irq` high; with bit 11 clear neither happens.
- R8: A control read returns the value held before the read, then clears control bits 22 and 5 and drives `irq` low.
- R9: A rotary read returns its value then clears bits 31, 30, 15 and 14; a matrix key read returns its value then clears bit 31; reads of other registers have no side effect.
- R10: An event whose row or column is 8 or more (including all ones, 4'hF) is dropped with no register change and no interrupt.
- R11: Reads of an unmapped or misaligned address return zero, and writes to one change no register.
- R12: When a taken event with interrupt enable and a control read fall in the same cycle, the read returns the old value and the event's status bit 22 and `irq` remain set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 7 | Byte address of the register access |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read strobe |
| busRdata | output | 32 | Read data, valid the cycle after busRe |
| keyValid | input | 1 | Key event strobe |
| keyRelease | input | 1 | Event is a release when high, a press when low |
| keyRow | input | 4 | Row of the key (0-7 valid) |
| keyCol | input | 4 | Column of the key (0-7 valid) |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a control read landing in the very cycle a key event sets the status bit, since the read clears what the event sets. The bench reaches it by raising the read strobe and the key strobe on the same falling edge, then checks that the read shows the old control value while the interrupt and status bit survive into the next read. The self-clearing scan mode bit is also checked: after it clears, a second event must be ignored.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

  // Matrix geometry and bus widths
  localparam int KP_ROWS   = 8;
  localparam int KP_COLS   = 8;
  localparam int KP_IDX_W  = 4;
  localparam int KP_DATA_W = 32;
  localparam int KP_ADDR_W = 7;

  localparam int KP_PAIRS  = KP_COLS / 2;
  localparam int KP_PAIR_W = $clog2(KP_PAIRS);
  localparam int KP_BIT_W  = KP_IDX_W + 1;
  localparam int KP_SEL_W  = KP_ADDR_W - 3;

  // Register indices (address = index * 8)
  localparam int RI_CTRL     = 0;
  localparam int RI_DIRECT   = 1;
  localparam int RI_ROTARY   = 2;
  localparam int RI_MATRIX   = 3;
  localparam int RI_AUTO     = 4;
  localparam int RI_SCAN0    = 5;
  localparam int RI_DEBOUNCE = RI_SCAN0 + KP_PAIRS;
  localparam int KP_NREGS    = RI_DEBOUNCE + 1;

  // Control bit positions
  localparam int CB_ONESHOT = 30;
  localparam int CB_ACTIVE  = 29;
  localparam int CB_MSTAT   = 22;
  localparam int CB_MEN     = 12;
  localparam int CB_MIE     = 11;
  localparam int CB_DSTAT   = 5;

  // Read-to-clear masks
  localparam logic [KP_DATA_W-1:0] ROT_CLR_MASK = 32'hC000_C000;
  localparam logic [KP_DATA_W-1:0] MAT_CLR_MASK = 32'h8000_0000;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 wrEn;
    logic                 rdEn;
    logic                 hit;
    logic [KP_SEL_W-1:0]  regIdx;
    logic                 evTake;
    logic                 evRelease;
    logic [KP_PAIR_W-1:0] evPair;
    logic [KP_BIT_W-1:0]  evBit;
  } kp_strobe_t;

endpackage

// File: rtl/keypad_ctrl.sv
module keypad_ctrl
  import keypad_pkg::*;
(
  input  logic [KP_ADDR_W-1:0] busAddr,
  input  logic                 busWe,
  input  logic                 busRe,
  input  logic                 keyValid,
  input  logic                 keyRelease,
  input  logic [KP_IDX_W-1:0]  keyRow,
  input  logic [KP_IDX_W-1:0]  keyCol,
  input  logic                 ctrlMen,
  input  logic                 ctrlOneShot,
  input  logic                 ctrlActive,
  output kp_strobe_t           stb
);

  logic aligned;
  logic inMap;
  logic keyInRange;

  assign aligned    = (busAddr[2:0] == 3'b000);
  assign inMap      = (int'(busAddr[KP_ADDR_W-1:3]) < KP_NREGS);
  assign keyInRange = (int'(keyRow) < KP_ROWS) && (int'(keyCol) < KP_COLS);

  always_comb begin
    stb.wrEn      = busWe;
    stb.rdEn      = busRe;
    stb.hit       = aligned && inMap;
    stb.regIdx    = busAddr[KP_ADDR_W-1:3];
    stb.evTake    = keyValid && keyInRange && ctrlMen && (ctrlOneShot || ctrlActive);
    stb.evRelease = keyRelease;
    stb.evPair    = keyCol[KP_PAIR_W:1];
    stb.evBit     = {keyCol[0], keyRow};
  end

endmodule

// File: rtl/keypad_dpath.sv
module keypad_dpath
  import keypad_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  kp_strobe_t           stb,
  input  logic [KP_DATA_W-1:0] busWdata,
  output logic [KP_DATA_W-1:0] busRdata,
  output logic                 irq,
  output logic [KP_DATA_W-1:0] ctrlView
);

  logic [KP_NREGS-1:0][KP_DATA_W-1:0] regQ;
  logic [KP_NREGS-1:0][KP_DATA_W-1:0] regNext;
  logic ctrlSel;

  assign ctrlSel  = stb.hit && (int'(stb.regIdx) == RI_CTRL);
  assign ctrlView = regQ[RI_CTRL];

  // Next state: read clears, then events, then bus writes (highest)
  always_comb begin
    regNext = regQ;
    for (int i = 0; i < KP_NREGS; i++) begin
      if (i == RI_CTRL) begin
        if (stb.rdEn && ctrlSel) begin
          regNext[i][CB_MSTAT] = 1'b0;
          regNext[i][CB_DSTAT] = 1'b0;
        end
        if (stb.evTake && regQ[i][CB_ONESHOT]) regNext[i][CB_ONESHOT] = 1'b0;
        if (stb.evTake && regQ[i][CB_MIE])     regNext[i][CB_MSTAT]   = 1'b1;
      end else if (i == RI_ROTARY) begin
        if (stb.rdEn && stb.hit && int'(stb.regIdx) == i)
          regNext[i] = regQ[i] & ~ROT_CLR_MASK;
      end else if (i == RI_MATRIX) begin
        if (stb.rdEn && stb.hit && int'(stb.regIdx) == i)
          regNext[i] = regQ[i] & ~MAT_CLR_MASK;
      end else if (i >= RI_SCAN0 && i < RI_SCAN0 + KP_PAIRS) begin
        if (stb.evTake && int'(stb.evPair) == i - RI_SCAN0) begin
          if (stb.evRelease) regNext[i] = '0;
          else               regNext[i][stb.evBit] = 1'b1;
        end
      end
      if (stb.wrEn && stb.hit && int'(stb.regIdx) == i)
        regNext[i] = busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) regQ <= '0;
    else       regQ <= regNext;
  end

  // Registered read data
  always_ff @(posedge clk) begin
    if (!rstN)         busRdata <= '0;
    else if (stb.rdEn) busRdata <= stb.hit ? regQ[stb.regIdx] : '0;
  end

  // Interrupt level: setting by an event wins over clearing by a read
  always_ff @(posedge clk) begin
    if (!rstN)                                 irq <= 1'b0;
    else if (stb.evTake && regQ[RI_CTRL][CB_MIE]) irq <= 1'b1;
    else if (stb.rdEn && ctrlSel)              irq <= 1'b0;
  end

endmodule

// File: rtl/keypad_regfile.sv
module keypad_regfile
  import keypad_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [KP_ADDR_W-1:0] busAddr,
  input  logic                 busWe,
  input  logic [KP_DATA_W-1:0] busWdata,
  input  logic                 busRe,
  output logic [KP_DATA_W-1:0] busRdata,
  input  logic                 keyValid,
  input  logic                 keyRelease,
  input  logic [KP_IDX_W-1:0]  keyRow,
  input  logic [KP_IDX_W-1:0]  keyCol,
  output logic                 irq
);

  kp_strobe_t stb;
  logic [KP_DATA_W-1:0] ctrlView;

  keypad_ctrl u_ctrl (
    .busAddr    (busAddr),
    .busWe      (busWe),
    .busRe      (busRe),
    .keyValid   (keyValid),
    .keyRelease (keyRelease),
    .keyRow     (keyRow),
    .keyCol     (keyCol),
    .ctrlMen    (ctrlView[CB_MEN]),
    .ctrlOneShot(ctrlView[CB_ONESHOT]),
    .ctrlActive (ctrlView[CB_ACTIVE]),
    .stb        (stb)
  );

  keypad_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irq      (irq),
    .ctrlView (ctrlView)
  );

endmodule

// File: rtl/keypad_regfile_chk.sv
module keypad_regfile_chk
  import keypad_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [KP_ADDR_W-1:0] busAddr,
  input logic                 busWe,
  input logic                 busRe,
  input logic [KP_DATA_W-1:0] busRdata,
  input logic                 keyValid,
  input logic [KP_IDX_W-1:0]  keyRow,
  input logic [KP_IDX_W-1:0]  keyCol,
  input logic                 irq,
  input logic [KP_DATA_W-1:0] ctrlView
);

  logic mapped;
  logic keyOk;
  assign mapped = (busAddr[2:0] == 3'b000) && (int'(busAddr[KP_ADDR_W-1:3]) < KP_NREGS);
  assign keyOk  = (int'(keyRow) < KP_ROWS) && (int'(keyCol) < KP_COLS);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(keyValid));

  // R8
  ctrl_read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && !busWe && busAddr == '0 && !keyValid)
      |=> (!irq && !ctrlView[CB_MSTAT] && !ctrlView[CB_DSTAT]));

  // R11
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && !mapped) |=> (busRdata == '0));

  // R3
  gated_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && !ctrlView[CB_MEN] && !busWe && !busRe)
      |=> ($stable(ctrlView) && $stable(irq)));

  // R10
  bad_key_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && !keyOk && !busWe && !busRe)
      |=> ($stable(ctrlView) && $stable(irq)));

  // R12
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && keyOk && ctrlView[CB_MEN] && ctrlView[CB_MIE]
      && (ctrlView[CB_ONESHOT] || ctrlView[CB_ACTIVE])
      && busRe && !busWe && busAddr == '0)
      |=> (irq && ctrlView[CB_MSTAT]));

endmodule

bind keypad_regfile keypad_regfile_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busRe    (busRe),
  .busRdata (busRdata),
  .keyValid (keyValid),
  .keyRow   (keyRow),
  .keyCol   (keyCol),
  .irq      (irq),
  .ctrlView (ctrlView)
);

// File: tb/keypad_regfile_test.sv
module keypad_regfile_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic        keyValid = 1'b0;
  logic        keyRelease = 1'b0;
  logic [3:0]  keyRow = '0;
  logic [3:0]  keyCol = '0;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  logic rdPending = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  keypad_regfile uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRe(busRe), .busRdata(busRdata), .keyValid(keyValid), .keyRelease(keyRelease),
    .keyRow(keyRow), .keyCol(keyCol), .irq(irq)
  );

  // Monitor side of the scoreboard
  always @(posedge clk) rdPending <= busRe;

  always @(negedge clk) begin
    if (rdPending) begin
      logic [31:0] e;
      string t;
      vectors++;
      if (expQ.size() == 0) begin
        miscompares++;
        $display("FAIL scoreboard: unexpected read data %h (expected none)", busRdata);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (busRdata !== e) begin
          miscompares++;
          $display("FAIL %s: read data %h expected %h", t, busRdata, e);
        end
      end
    end
  end

  function automatic logic [31:0] pat(int i);
    return 32'hC3C3_C3C3 ^ (i * 32'h0001_0101);
  endfunction

  task automatic writeReg(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readReg(input logic [6:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    expQ.push_back(e); tagQ.push_back(t);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic keyEvent(input logic rel, input logic [3:0] r, input logic [3:0] c);
    @(negedge clk);
    keyRelease = rel; keyRow = r; keyCol = c; keyValid = 1'b1;
    @(negedge clk);
    keyValid = 1'b0;
  endtask

  task automatic checkIrq(input logic e, input string t);
    vectors++;
    if (irq !== e) begin
      miscompares++;
      $display("FAIL %s: irq %b expected %b", t, irq, e);
    end
  endtask

  task automatic finishRun();
    if (expQ.size() != 0) begin
      miscompares++;
      $display("FAIL scoreboard: %0d reads never returned data (expected 0)", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog: run did not end (expected completion)");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkIrq(1'b0, "R1 irq after reset");
    for (int i = 0; i < 10; i++) readReg(7'(i * 8), 32'h0, "R1 reset value");

    // R2 full-width write and readback at every offset
    for (int i = 0; i < 10; i++) writeReg(7'(i * 8), pat(i));
    for (int i = 0; i < 10; i++) readReg(7'(i * 8), pat(i), "R2 readback");
    // R8 / R9 second reads show the read side effects
    readReg(7'h00, pat(0) & ~32'h0040_0020, "R8 ctrl status cleared by read");
    readReg(7'h08, pat(1), "R9 direct read has no side effect");
    readReg(7'h10, pat(2) & ~32'hC000_C000, "R9 rotary flags cleared by read");
    readReg(7'h18, pat(3) & ~32'h8000_0000, "R9 matrix flag cleared by read");
    readReg(7'h20, pat(4), "R9 auto scan read has no side effect");
    for (int i = 0; i < 10; i++) writeReg(7'(i * 8), 32'h0);

    // R3 gating
    keyEvent(1'b0, 4'd2, 4'd3);
    readReg(7'h30, 32'h0, "R3 event ignored with control clear");
    writeReg(7'h00, 32'h0000_1000);
    keyEvent(1'b0, 4'd2, 4'd3);
    readReg(7'h30, 32'h0, "R3 event ignored with no scan mode");
    writeReg(7'h00, 32'h2000_1000);
    keyEvent(1'b0, 4'd2, 4'd3);
    checkIrq(1'b0, "R7 no irq without enable");
    readReg(7'h30, 32'h0004_0000, "R4 press row2 col3");
    readReg(7'h00, 32'h2000_1000, "R7 no status without enable");

    // R4 accumulate and placement
    keyEvent(1'b0, 4'd5, 4'd2);
    readReg(7'h30, 32'h0004_0020, "R4 press row5 col2 keeps earlier bit");
    keyEvent(1'b0, 4'd7, 4'd7);
    keyEvent(1'b0, 4'd0, 4'd0);
    readReg(7'h40, 32'h0080_0000, "R4 press row7 col7");
    readReg(7'h28, 32'h0000_0001, "R4 press row0 col0");

    // R5 release wipes its pair only
    keyEvent(1'b1, 4'd1, 4'd3);
    readReg(7'h30, 32'h0, "R5 release clears pair register");
    readReg(7'h40, 32'h0080_0000, "R5 other pair untouched");
    readReg(7'h28, 32'h0000_0001, "R5 other pair untouched");

    // R6 / R7 one-shot scan with interrupt enable
    writeReg(7'h00, 32'h4000_1800);
    keyEvent(1'b0, 4'd1, 4'd4);
    checkIrq(1'b1, "R7 irq after taken event");
    readReg(7'h38, 32'h0000_0002, "R4 press row1 col4");
    readReg(7'h00, 32'h0040_1800, "R6 one-shot bit cleared, R7 status set");
    checkIrq(1'b0, "R8 irq dropped by control read");
    readReg(7'h00, 32'h0000_1800, "R8 status cleared");
    keyEvent(1'b0, 4'd3, 4'd4);
    checkIrq(1'b0, "R3 no irq once scan mode cleared");
    readReg(7'h38, 32'h0000_0002, "R3 event ignored after one-shot");

    // R10 out-of-range keys
    writeReg(7'h00, 32'h2000_1800);
    keyEvent(1'b0, 4'hF, 4'd1);
    keyEvent(1'b0, 4'd1, 4'hF);
    keyEvent(1'b0, 4'd8, 4'd0);
    checkIrq(1'b0, "R10 no irq for bad key");
    readReg(7'h28, 32'h0000_0001, "R10 bad key dropped");
    readReg(7'h00, 32'h2000_1800, "R10 control unchanged");

    // R12 event and control read in the same cycle
    @(negedge clk);
    expQ.push_back(32'h2000_1800); tagQ.push_back("R12 read returns old value");
    busAddr = 7'h00; busRe = 1'b1;
    keyRelease = 1'b0; keyRow = 4'd6; keyCol = 4'd6; keyValid = 1'b1;
    @(negedge clk);
    busRe = 1'b0; keyValid = 1'b0;
    checkIrq(1'b1, "R12 irq survives simultaneous read");
    readReg(7'h00, 32'h2040_1800, "R12 status survives simultaneous read");
    checkIrq(1'b0, "R8 irq dropped by later read");
    readReg(7'h40, 32'h0080_0040, "R4 press row6 col6");

    // R11 unmapped and misaligned
    writeReg(7'h60, 32'hFFFF_FFFF);
    writeReg(7'h4C, 32'hFFFF_FFFF);
    readReg(7'h60, 32'h0, "R11 unmapped read");
    readReg(7'h04, 32'h0, "R11 misaligned read");
    readReg(7'h50, 32'h0, "R11 unmapped read");
    readReg(7'h48, 32'h0, "R11 misaligned write ignored");
    readReg(7'h08, 32'h0, "R11 unmapped write ignored");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule